// File: doc/BRIEF.md
# Oversampling Serial Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial characters from a single input line. It runs the line through a two-flop synchronizer and counts an oversampling tick, `OVS` ticks per bit. A falling edge on an idle line starts a frame. The block confirms the start bit at mid-bit with a three-sample majority vote, then takes each data bit near its centre, least significant bit first. It assembles 8 or 9 data bits and finally samples the stop bit.

Finished characters go into a small first-in first-out store of `DEPTH` entries (two by default). Each entry holds the data byte, the ninth bit and its own framing-error flag. The host sees the oldest entry on the read outputs and removes it with a one-cycle read strobe.

In 9-bit mode with address filtering switched on, only characters whose ninth bit is 1 are stored. A node on a shared multi-drop line can use this to skip data frames meant for other nodes.

If a character that would be stored finishes while the store is full, the block raises a sticky overrun flag and throws that character away. The receiver then stays idle until the host clears the flag by dropping the enable.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_avail` and `overrun` are 0.
- R2: In 8-bit mode (`nine_bit`=0) a frame is one low start bit, 8 data bits sent least significant bit first, and one stop bit. The stored byte appears on `rd_data` with `rd_bit9`=0.
- R3: In 9-bit mode (`nine_bit`=1) a ninth data bit follows the eighth. It is delivered on `rd_bit9` together with its byte.
- R4: With `nine_bit`=1 and `addr_det`=1, a character whose ninth bit is 0 is not stored and a character whose ninth bit is 1 is stored. With `addr_det`=0, every character is stored.
- R5: A character whose stop bit is sampled low is still stored, with `rd_ferr`=1. The flag belongs to that entry only.
- R6: The buffer holds up to two characters and returns them in arrival order. `rx_avail` is 1 exactly while at least one character is held.
- R7: A storable character that finishes while the buffer is full sets `overrun` and is discarded. The held characters are unaffected.
- R8: While `overrun` is 1, no new frame is received. Driving `rx_en` low clears `overrun`, and reception resumes once `rx_en` is 1 again.
- R9: A low pulse on `rxd` shorter than half a bit time is rejected as a false start and stores nothing.
- R10: A read strobe (`rd_en`=1) while the buffer is empty has no effect.
- R11: One bit time is `OVS*(baud_div+1)` clock cycles, and the tick divider is realigned at each detected start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low clears the overrun flag |
| nine_bit | input | 1 | 1 selects 9 data bits per character |
| addr_det | input | 1 | 1 enables ninth-bit address filtering in 9-bit mode |
| baud_div | input | DIV_W | Clock cycles per oversampling tick, minus one |
| rxd | input | 1 | Serial input line, idle high |
| rd_en | input | 1 | Removes the oldest character from the buffer |
| rd_data | output | 8 | Data byte of the oldest character |
| rd_bit9 | output | 1 | Ninth bit of the oldest character |
| rd_ferr | output | 1 | Framing-error flag of the oldest character |
| rx_avail | output | 1 | At least one character is held |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong bit counter or a misplaced sample point shows up when the first character is read back, one frame time after it was sent. It appears as a shifted byte, a wrong ninth bit or a spurious framing flag. A broken buffer pointer or fill count first shows when the second or third character arrives. It appears as swapped order, `rx_avail` failing to drop, or `overrun` rising one character early or late. A receiver that fails to park during overrun shows up only after the flag is cleared, when a frame sent during the overrun turns up on the read outputs.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       bit9;
    logic       ferr;
  } rx_char_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  // Majority of three samples.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Number of data bits in a frame.
  function automatic logic [3:0] data_bits(input logic nine);
    return nine ? 4'd9 : 4'd8;
  endfunction

  // Address filter: in filtered 9-bit mode only ninth-bit-set characters pass.
  function automatic logic keep_char(input logic nine, input logic adr, input logic b9);
    return !(nine && adr) || b9;
  endfunction

  // The shift register fills from the top, so an 8-bit frame ends one place higher.
  function automatic rx_char_t unpack_shift(input logic [8:0] sh, input logic nine,
                                            input logic ferr);
    rx_char_t c;
    c.data = nine ? sh[7:0] : sh[8:1];
    c.bit9 = nine ? sh[8] : 1'b0;
    c.ferr = ferr;
    return c;
  endfunction

endpackage

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_addr_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold,
  input  logic     nine_bit,
  input  logic     rxd,
  input  logic     tick,
  output logic     start_o,
  output logic     done_o,
  output logic     nine_o,
  output rx_char_t char_o
);

  localparam int CW  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] S_A  = CW'(MID - 1);
  localparam logic [CW-1:0] S_B  = CW'(MID);
  localparam logic [CW-1:0] S_C  = CW'(MID + 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic            sync1, sync2, rx_prev;
  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [3:0]      bidx;
  logic            smp_a, smp_b;
  logic [8:0]      shreg;
  logic            nine_q;
  logic            ferr_q;
  logic            done_q;
  logic            vote;
  logic            at_vote;
  logic            at_end;

  assign vote    = vote3(smp_a, smp_b, sync2);
  assign at_vote = tick && (cnt == S_C);
  assign at_end  = tick && (cnt == LAST);
  assign start_o = (state == ST_IDLE) && !hold && rx_prev && !sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      sync1   <= rxd;
      sync2   <= sync1;
      rx_prev <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      smp_a  <= 1'b1;
      smp_b  <= 1'b1;
      shreg  <= '0;
      nine_q <= 1'b0;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (hold) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (state == ST_IDLE) begin
        cnt  <= '0;
        bidx <= '0;
        if (start_o) begin
          state  <= ST_START;
          nine_q <= nine_bit;
        end
      end else begin
        if (tick) begin
          cnt <= at_end ? '0 : cnt + 1'b1;
          if (cnt == S_A) smp_a <= sync2;
          if (cnt == S_B) smp_b <= sync2;
        end
        if (at_vote) begin
          unique case (state)
            ST_START: if (vote) state <= ST_IDLE;
            ST_DATA:  shreg <= {vote, shreg[8:1]};
            ST_STOP: begin
              ferr_q <= !vote;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
        if (at_end) begin
          if (state == ST_START) begin
            state <= ST_DATA;
          end else if (state == ST_DATA) begin
            bidx <= bidx + 1'b1;
            if (bidx == data_bits(nine_q) - 4'd1) state <= ST_STOP;
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign nine_o = nine_q;
  assign char_o = unpack_shift(shreg, nine_q, ferr_q);

endmodule

// File: rtl/rx_char_buf.sv
module rx_char_buf
  import uart_addr_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  rx_char_t                   wr_char,
  input  logic                       pop,
  output rx_char_t                   head,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] fill
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

  rx_char_t        mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [FW-1:0]   cnt;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PMAX) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == FW'(DEPTH));
  assign empty = (cnt == '0);
  assign fill  = cnt;
  assign head  = mem[rp];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[i] <= '0;
        end else if (push && !full && (wp == PW'(i))) begin
          mem[i] <= wr_char;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= next_ptr(wp);
      if (pop && !empty) rp <= next_ptr(rp);
      unique case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_addr_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 2,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             nine_bit,
  input  logic             addr_det,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rxd,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_bit9,
  output logic             rd_ferr,
  output logic             rx_avail,
  output logic             overrun
);

  localparam int FW = $clog2(DEPTH + 1);

  logic          hold;
  logic          tick;
  logic          start_edge;
  logic          frame_done;
  logic          frame_nine;
  rx_char_t      frame_char;
  logic          frame_keep;
  logic          push;
  logic          drop;
  logic          pop;
  logic          buf_full;
  logic          buf_empty;
  logic [FW-1:0] fill;
  rx_char_t      head;
  logic          ovr_q;

  assign hold = !rx_en || ovr_q;

  rx_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_edge),
    .div     (baud_div),
    .tick    (tick)
  );

  rx_framer #(.OVS(OVS)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .nine_bit (nine_bit),
    .rxd      (rxd),
    .tick     (tick),
    .start_o  (start_edge),
    .done_o   (frame_done),
    .nine_o   (frame_nine),
    .char_o   (frame_char)
  );

  assign frame_keep = frame_done && keep_char(frame_nine, addr_det, frame_char.bit9);
  assign push       = frame_keep && !buf_full;
  assign drop       = frame_keep && buf_full;
  assign pop        = rd_en && !buf_empty;

  rx_char_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .wr_char (frame_char),
    .pop     (pop),
    .head    (head),
    .full    (buf_full),
    .empty   (buf_empty),
    .fill    (fill)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (!rx_en) begin
      ovr_q <= 1'b0;
    end else if (drop) begin
      ovr_q <= 1'b1;
    end
  end

  assign rd_data  = head.data;
  assign rd_bit9  = head.bit9;
  assign rd_ferr  = head.ferr;
  assign rx_avail = !buf_empty;
  assign overrun  = ovr_q;

endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       nine_bit,
  input logic                       addr_det,
  input logic                       rd_en,
  input logic                       rx_avail,
  input logic                       overrun,
  input logic                       frame_done,
  input logic                       frame_b9,
  input logic                       push,
  input logic                       drop,
  input logic [$clog2(DEPTH+1)-1:0] fill
);

  // R6: fill never exceeds the store size
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  // R6: a stored character makes data available on the next cycle
  a_r6_avail_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rx_avail);

  // R4: filtered 9-bit mode stores only characters with ninth bit set
  a_r4_filter_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (push && nine_bit && addr_det) |-> frame_b9);

  // R7: a character is discarded only when the store is full
  a_r7_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (fill == ($clog2(DEPTH+1))'(DEPTH)));

  // R7: overrun rises only after a discard
  a_r7_overrun_from_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(drop));

  // R8: no frame completes while overrun is held
  a_r8_parked_in_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !frame_done);

  // R8: disabling clears overrun
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);

  // R10: a read on an empty store leaves it empty
  a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (fill == '0) && !push) |=> (fill == '0));

endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .nine_bit   (nine_bit),
  .addr_det   (addr_det),
  .rd_en      (rd_en),
  .rx_avail   (rx_avail),
  .overrun    (overrun),
  .frame_done (frame_done),
  .frame_b9   (frame_char.bit9),
  .push       (push),
  .drop       (drop),
  .fill       (fill)
);

// File: tb/tb_uart_addr_rx.sv
module tb_uart_addr_rx;

  localparam int OVS   = 16;
  localparam int DIV_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_en = 1'b0;
  logic             nine_bit = 1'b0;
  logic             addr_det = 1'b0;
  logic [DIV_W-1:0] baud_div = '0;
  logic             rxd = 1'b1;
  logic             rd_en = 1'b0;
  logic [7:0]       rd_data;
  logic             rd_bit9;
  logic             rd_ferr;
  logic             rx_avail;
  logic             overrun;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  uart_addr_rx #(.OVS(OVS), .DEPTH(2), .DIV_W(DIV_W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .nine_bit (nine_bit),
    .addr_det (addr_det),
    .baud_div (baud_div),
    .rxd      (rxd),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_bit9  (rd_bit9),
    .rd_ferr  (rd_ferr),
    .rx_avail (rx_avail),
    .overrun  (overrun)
  );

  // [13] nine, [12] addr filter, [11:3] frame bits, [2] stop level,
  // [1] expected stored, [0] expected framing error
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 1'b0, 9'h0A5, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 9'h000, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 9'h0FF, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 9'h13C, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 9'h055, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 9'h0AA, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 9'h1C3, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 9'h081, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] f, input logic nine, input logic stop, input int cpb);
    @(negedge clk);
    rxd = 1'b0;
    wait_clk(cpb);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd = f[i];
      wait_clk(cpb);
    end
    rxd = stop;
    wait_clk(cpb);
    rxd = 1'b1;
    wait_clk(4);
  endtask

  task automatic read_one;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d, input logic b9, input logic fe);
    chk({req, " avail"}, 32'(rx_avail), 32'd1);
    chk({req, " data"},  32'(rd_data),  32'(d));
    chk({req, " bit9"},  32'(rd_bit9),  32'(b9));
    chk({req, " ferr"},  32'(rd_ferr),  32'(fe));
    read_one();
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(3);
    // R1: reset state
    chk("R1 avail", 32'(rx_avail), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    wait_clk(3);
    chk("R1 avail after release", 32'(rx_avail), 32'd0);

    // R2 R3 R4 R5: vector table
    foreach (VEC[k]) begin
      nine_bit = VEC[k][13];
      addr_det = VEC[k][12];
      wait_clk(2);
      send(VEC[k][11:3], VEC[k][13], VEC[k][2], OVS);
      if (VEC[k][1]) begin
        expect_char($sformatf("R2/R3/R4/R5 vec%0d", k), VEC[k][10:3],
                    VEC[k][13] & VEC[k][11], VEC[k][0]);
        chk($sformatf("R6 vec%0d empty after read", k), 32'(rx_avail), 32'd0);
      end else begin
        chk($sformatf("R4 vec%0d filtered", k), 32'(rx_avail), 32'd0);
      end
    end

    // R6 R5: two characters, arrival order, per-entry framing flag
    nine_bit = 1'b0;
    addr_det = 1'b0;
    send(9'h011, 1'b0, 1'b1, OVS);
    send(9'h022, 1'b0, 1'b0, OVS);
    chk("R7 no overrun with two held", 32'(overrun), 32'd0);
    expect_char("R6 first", 8'h11, 1'b0, 1'b0);
    expect_char("R5 second ferr", 8'h22, 1'b0, 1'b1);
    chk("R6 empty", 32'(rx_avail), 32'd0);

    // R7 R8: overrun
    send(9'h0A1, 1'b0, 1'b1, OVS);
    send(9'h0B2, 1'b0, 1'b1, OVS);
    send(9'h0C3, 1'b0, 1'b1, OVS);
    chk("R7 overrun set", 32'(overrun), 32'd1);
    send(9'h0D4, 1'b0, 1'b1, OVS);
    expect_char("R7 kept first", 8'hA1, 1'b0, 1'b0);
    expect_char("R7 kept second", 8'hB2, 1'b0, 1'b0);
    chk("R8 nothing received during overrun", 32'(rx_avail), 32'd0);
    chk("R8 overrun still set", 32'(overrun), 32'd1);
    rx_en = 1'b0;
    wait_clk(2);
    chk("R8 cleared by disable", 32'(overrun), 32'd0);
    rx_en = 1'b1;
    wait_clk(2);
    send(9'h0E5, 1'b0, 1'b1, OVS);
    expect_char("R8 resumes", 8'hE5, 1'b0, 1'b0);

    // R9: short glitch rejected, then a valid frame still decodes
    @(negedge clk);
    rxd = 1'b0;
    wait_clk(3);
    rxd = 1'b1;
    wait_clk(40);
    chk("R9 glitch ignored", 32'(rx_avail), 32'd0);
    send(9'h05A, 1'b0, 1'b1, OVS);
    expect_char("R9 after glitch", 8'h5A, 1'b0, 1'b0);

    // R10: read on empty has no effect
    read_one();
    read_one();
    chk("R10 still empty", 32'(rx_avail), 32'd0);
    send(9'h03C, 1'b0, 1'b1, OVS);
    expect_char("R10 next char intact", 8'h3C, 1'b0, 1'b0);
    chk("R10 empty again", 32'(rx_avail), 32'd0);

    // R11: divider of 1 gives two clocks per tick
    baud_div = 12'd1;
    wait_clk(2);
    send(9'h096, 1'b0, 1'b1, 2 * OVS);
    expect_char("R11 slow baud", 8'h96, 1'b0, 1'b0);
    nine_bit = 1'b1;
    send(9'h169, 1'b1, 1'b1, 2 * OVS);
    expect_char("R11 R3 slow nine-bit", 8'h69, 1'b1, 1'b0);

    finish_run();
  end

endmodule